// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches the destination address at the head of each incoming Ethernet frame and decides whether the frame should be kept. Bytes arrive one per accepted cycle on a byte stream; a start-of-frame flag marks the first byte and an end flag marks the last byte. Once the sixth address byte has been taken, the block classifies the address as broadcast, multicast or unicast and produces an accept or reject verdict one clock later. The verdict is held until the next frame begins.

Acceptance depends on an 8-bit receive configuration word, a 48-bit station address and a 64-entry multicast hash table. A CRC-32 runs over the address bytes as they arrive, one byte per clock, so the multicast hash index is ready in the same cycle as the last address byte. Frame storage and whole-frame CRC checking are handled elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: With rx_cfg bit 4 set, every frame of at least six bytes is accepted, whatever its address class.
- R2: An address of six 0xFF bytes has class 2'b10 (broadcast) and, outside R1, is accepted exactly when rx_cfg bit 2 is set.
- R3: Any other address whose first byte has bit 0 set has class 2'b01 (multicast) and, outside R1, is accepted only when rx_cfg bit 3 is set and the selected hash table bit is 1.
- R4: The hash index is bits 31:26 of a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, shifted left, each byte fed least significant bit first, no final inversion) over the six address bytes; index i selects mcast_table bit i, which is bit i&7 of table byte i>>3 held at mcast_table[8*(i>>3)+7 : 8*(i>>3)].
- R5: Every remaining address has class 2'b00 (unicast) and, outside R1, is accepted only when all six bytes equal station_addr, where byte k of the wire order sits at station_addr[8k+7:8k].
- R6: dec_valid rises on the clock edge that takes the sixth address byte, so it is seen one clock after that byte, also when idle cycles separate the bytes.
- R7: After a verdict, dec_valid, dec_accept and dec_class hold until the next start of frame; further bytes and changes to the configuration, station address or table have no effect on them.
- R8: A byte taken with frame_start set (and not frame_last) clears dec_valid one clock later.
- R9: A frame whose frame_last byte comes before the sixth byte yields dec_valid with dec_accept low and class 2'b11, even with R1 in force.
- R10: Bytes presented without frame_start while no frame is open leave all outputs unchanged.
- R11: After reset, dec_valid and dec_accept are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | A byte is present on byte_data this cycle |
| frame_start | input | 1 | The present byte is the first of a frame |
| frame_last | input | 1 | The present byte is the last of a frame |
| byte_data | input | 8 | Stream byte |
| rx_cfg | input | 8 | Receive configuration: bit 2 broadcast, bit 3 multicast, bit 4 promiscuous |
| station_addr | input | 48 | Station address, wire byte k at bits 8k+7:8k |
| mcast_table | input | 64 | Multicast hash table, one bit per hash index |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Frame is to be kept |
| dec_class | output | 2 | 00 unicast, 01 multicast, 10 broadcast, 11 short frame |

## Verification
The assertions assume the configuration bits are steady on the edge that takes the sixth address byte and that frame_start and frame_last only matter when byte_vld is high. The stimulus changes rx_cfg, station_addr and mcast_table only between frames, during idle cycles, and raises the framing flags only together with byte_vld, so every verdict is formed from settled settings. The hold test then changes the settings on purpose after a verdict to show it no longer listens to them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    typedef enum logic [1:0] {
        CLS_UCAST = 2'b00,
        CLS_MCAST = 2'b01,
        CLS_BCAST = 2'b10,
        CLS_SHORT = 2'b11
    } rxf_class_e;

endpackage

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             en,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc_nxt
);

    logic [CRC_W-1:0] crc_d;
    logic [CRC_W-1:0] crc_q;

    // Serial shift over one byte per clock, least significant bit first.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = restart ? '1 : crc_q;
        for (int i = 0; i < 8; i++) begin
            fb  = acc[CRC_W-1] ^ din[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc_d = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= '1;
        else if (en)  crc_q <= crc_d;
    end

    assign crc_nxt = crc_d;

    // R4: an idle cycle keeps the running remainder
    a_r4_crc_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> crc_q == $past(crc_q));

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int CFG_W       = 8,
    parameter int HASH_BITS   = 6,
    parameter int BIT_BCAST   = 2,
    parameter int BIT_MCAST   = 3,
    parameter int BIT_PROMISC = 4,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int TABLE_W    = 1 << HASH_BITS
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CRC_W-1:0]   crc,
    input  logic [CFG_W-1:0]   cfg,
    input  logic [ADDR_W-1:0]  station,
    input  logic [TABLE_W-1:0] table_bits,
    output logic               accept,
    output rxf_class_e         cls
);

    logic [HASH_BITS-1:0] hidx;
    logic                 is_bcast;
    logic                 is_mcast;
    logic                 own_hit;
    logic                 class_ok;

    always_comb begin
        hidx     = crc[CRC_W-1 -: HASH_BITS];
        is_bcast = &addr;
        is_mcast = addr[0] & ~is_bcast;
        own_hit  = (addr == station);
        if (is_bcast) begin
            cls      = CLS_BCAST;
            class_ok = cfg[BIT_BCAST];
        end else if (is_mcast) begin
            cls      = CLS_MCAST;
            class_ok = cfg[BIT_MCAST] & table_bits[hidx];
        end else begin
            cls      = CLS_UCAST;
            class_ok = own_hit;
        end
        accept = cfg[BIT_PROMISC] | class_ok;
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int CFG_W       = 8,
    parameter int HASH_BITS   = 6,
    parameter int BIT_BCAST   = 2,
    parameter int BIT_MCAST   = 3,
    parameter int BIT_PROMISC = 4,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int TABLE_W    = 1 << HASH_BITS,
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld,
    input  logic               frame_start,
    input  logic               frame_last,
    input  logic [7:0]         byte_data,
    input  logic [CFG_W-1:0]   rx_cfg,
    input  logic [ADDR_W-1:0]  station_addr,
    input  logic [TABLE_W-1:0] mcast_table,
    output logic               dec_valid,
    output logic               dec_accept,
    output logic [1:0]         dec_class
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic              open;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic              accept;
        rxf_class_e        cls;
    } flt_state_t;

    flt_state_t        st_d, st_q;
    logic              take;
    logic [CNT_W-1:0]  idx;
    logic [ADDR_W-1:0] full_addr;
    logic [CRC_W-1:0]  crc_nxt;
    logic              cls_accept;
    rxf_class_e        cls_kind;

    assign take = byte_vld & (frame_start | st_q.open);
    assign idx  = frame_start ? '0 : st_q.cnt;

    rxf_crc_hash u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .en      (take),
        .din     (byte_data),
        .crc_nxt (crc_nxt)
    );

    rxf_classify #(
        .ADDR_BYTES  (ADDR_BYTES),
        .CFG_W       (CFG_W),
        .HASH_BITS   (HASH_BITS),
        .BIT_BCAST   (BIT_BCAST),
        .BIT_MCAST   (BIT_MCAST),
        .BIT_PROMISC (BIT_PROMISC)
    ) u_cls (
        .addr       (full_addr),
        .crc        (crc_nxt),
        .cfg        (rx_cfg),
        .station    (station_addr),
        .table_bits (mcast_table),
        .accept     (cls_accept),
        .cls        (cls_kind)
    );

    // Address with the byte on the wire merged in at its slot.
    always_comb begin
        full_addr = st_q.addr;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == CNT_W'(k)) full_addr[8*k +: 8] = byte_data;
        end
    end

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.addr = full_addr;
            st_d.cnt  = idx + 1'b1;
            st_d.open = 1'b1;
            if (frame_start) st_d.valid = 1'b0;
            if (idx == LAST_IDX) begin
                st_d.valid  = 1'b1;
                st_d.accept = cls_accept;
                st_d.cls    = cls_kind;
                st_d.open   = 1'b0;
            end else if (frame_last) begin
                st_d.valid  = 1'b1;
                st_d.accept = 1'b0;
                st_d.cls    = CLS_SHORT;
                st_d.open   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{open: 1'b0, cnt: '0, addr: '0, valid: 1'b0,
                      accept: 1'b0, cls: CLS_UCAST};
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid  = st_q.valid;
    assign dec_accept = st_q.accept;
    assign dec_class  = st_q.cls;

    // R6: the sixth address byte yields a verdict on the next clock
    a_r6_verdict_after_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
        take && idx == LAST_IDX |=> dec_valid);

    // R8: a new frame withdraws the previous verdict
    a_r8_start_clears_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld && frame_start && !frame_last |=> !dec_valid);

    // R7: a verdict stays put until the next frame start
    a_r7_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !(byte_vld && frame_start)
        |=> dec_valid && $stable(dec_accept) && $stable(dec_class));

    // R9: a short frame is never kept
    a_r9_short_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_class == CLS_SHORT |-> !dec_accept);

    // R2: broadcast follows its own enable when not promiscuous
    a_r2_bcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) && dec_class == CLS_BCAST && !$past(rx_cfg[BIT_PROMISC])
        |-> dec_accept == $past(rx_cfg[BIT_BCAST]));

    // R1: promiscuous keeps every full-length frame
    a_r1_promisc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) && dec_class != CLS_SHORT && $past(rx_cfg[BIT_PROMISC])
        |-> dec_accept);

endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic        frame_start = 1'b0;
    logic        frame_last = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [7:0]  rx_cfg = 8'h00;
    logic [47:0] station_addr = 48'h0;
    logic [63:0] mcast_table = 64'h0;
    logic        dec_valid;
    logic        dec_accept;
    logic [1:0]  dec_class;

    int total = 0;
    int bad   = 0;
    logic [7:0] fr [0:7];

    always #4 clk = ~clk;

    rx_addr_filter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld     (byte_vld),
        .frame_start  (frame_start),
        .frame_last   (frame_last),
        .byte_data    (byte_data),
        .rx_cfg       (rx_cfg),
        .station_addr (station_addr),
        .mcast_table  (mcast_table),
        .dec_valid    (dec_valid),
        .dec_accept   (dec_accept),
        .dec_class    (dec_class)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got {valid,accept,class}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic check_dec(input string req, input logic v, input logic a, input logic [1:0] c);
        check(req, {dec_valid, dec_accept, dec_class}, {v, a, c});
    endtask

    // Bench model of the hash index.
    function automatic logic [5:0] hash_idx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int b = 0; b < 48; b++) begin
            logic top = r[31];
            r = r << 1;
            if (top != a[b]) r = r ^ 32'h04C11DB7;
        end
        return r[31:26];
    endfunction

    function automatic logic [47:0] pack_fr();
        logic [47:0] v;
        for (int k = 0; k < 6; k++) v[8*k +: 8] = fr[k];
        return v;
    endfunction

    task automatic load(input logic [47:0] a);
        for (int k = 0; k < 6; k++) fr[k] = a[8*k +: 8];
        fr[6] = 8'hA5;
        fr[7] = 8'h5A;
    endtask

    task automatic send(input int n, input bit with_start, input bit with_last, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld    = 1'b1;
            frame_start = with_start && (i == 0);
            frame_last  = with_last && (i == n - 1);
            byte_data   = fr[i];
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                byte_vld = 1'b0; frame_start = 1'b0; frame_last = 1'b0;
            end
        end
        @(negedge clk);
        byte_vld = 1'b0; frame_start = 1'b0; frame_last = 1'b0;
    endtask

    task automatic t_reset();
        check_dec("R11 reset", 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_unicast();
        station_addr = 48'h55_44_33_22_11_02;
        rx_cfg = 8'h00;
        load(station_addr);
        send(6, 1, 0, 0);
        check_dec("R5 R6 unicast match", 1'b1, 1'b1, 2'b00);
        load(station_addr ^ 48'h01_00_00_00_00_00);
        send(6, 1, 1, 2);
        check_dec("R5 R6 unicast last byte differs, gapped", 1'b1, 1'b0, 2'b00);
        load(station_addr ^ 48'h00_00_00_00_00_04);
        send(6, 1, 0, 0);
        check_dec("R5 unicast first byte differs", 1'b1, 1'b0, 2'b00);
    endtask

    task automatic t_bcast();
        load(48'hFFFF_FFFF_FFFF);
        rx_cfg = 8'h04;
        send(6, 1, 0, 0);
        check_dec("R2 broadcast enabled", 1'b1, 1'b1, 2'b10);
        rx_cfg = 8'h08;
        mcast_table = '1;
        send(6, 1, 0, 0);
        check_dec("R2 broadcast disabled", 1'b1, 1'b0, 2'b10);
        mcast_table = '0;
    endtask

    task automatic t_mcast();
        logic [5:0] h;
        load(48'hFB_00_00_5E_00_01);
        h = hash_idx(pack_fr());
        rx_cfg = 8'h08;
        mcast_table = 64'h1 << h;
        send(6, 1, 0, 0);
        check_dec("R3 R4 multicast hash hit", 1'b1, 1'b1, 2'b01);
        mcast_table = ~(64'h1 << h);
        send(6, 1, 0, 1);
        check_dec("R3 R4 multicast hash miss", 1'b1, 1'b0, 2'b01);
        rx_cfg = 8'h04;
        mcast_table = '1;
        send(6, 1, 0, 0);
        check_dec("R3 multicast disabled", 1'b1, 1'b0, 2'b01);
        load(48'h33_22_11_00_5E_01);
        h = hash_idx(pack_fr());
        rx_cfg = 8'h08;
        mcast_table = 64'h1 << h;
        send(6, 1, 0, 0);
        check_dec("R4 second address hit", 1'b1, 1'b1, 2'b01);
        mcast_table = '0;
    endtask

    task automatic t_promisc();
        rx_cfg = 8'h10;
        load(48'h99_88_77_66_55_40);
        send(6, 1, 0, 0);
        check_dec("R1 promiscuous foreign unicast", 1'b1, 1'b1, 2'b00);
        load(48'h01_02_03_04_05_07);
        send(6, 1, 0, 0);
        check_dec("R1 promiscuous multicast empty table", 1'b1, 1'b1, 2'b01);
    endtask

    task automatic t_short();
        rx_cfg = 8'h1C;
        load(48'hFFFF_FFFF_FFFF);
        send(4, 1, 1, 0);
        check_dec("R9 four byte frame", 1'b1, 1'b0, 2'b11);
        send(1, 1, 1, 0);
        check_dec("R9 one byte frame", 1'b1, 1'b0, 2'b11);
    endtask

    task automatic t_no_start();
        rx_cfg = 8'h10;
        load(48'hFFFF_FFFF_FFFF);
        send(6, 0, 0, 0);
        check_dec("R10 bytes without start", 1'b1, 1'b0, 2'b11);
    endtask

    task automatic t_hold();
        station_addr = 48'h55_44_33_22_11_02;
        rx_cfg = 8'h00;
        load(station_addr);
        send(8, 1, 1, 0);
        check_dec("R7 trailing bytes ignored", 1'b1, 1'b1, 2'b00);
        rx_cfg = 8'h00;
        station_addr = 48'h0;
        repeat (3) @(negedge clk);
        check_dec("R7 settings change ignored", 1'b1, 1'b1, 2'b00);
    endtask

    task automatic t_start_clears();
        station_addr = 48'h55_44_33_22_11_02;
        load(station_addr);
        send(3, 1, 0, 0);
        check_dec("R8 new frame clears verdict", 1'b0, 1'b1, 2'b00);
        send(6, 1, 0, 0);
        check_dec("R6 verdict after restart", 1'b1, 1'b1, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_bcast();
        t_mcast();
        t_promisc();
        t_short();
        t_no_start();
        t_hold();
        t_start_clears();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule